// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives an SDRAM device from power-up to a state where normal accesses may begin. After a synchronous reset it raises clock enable and holds NOP on the command pins for a programmable startup interval. It then issues one precharge of all banks and a programmable number of auto-refresh commands, and writes a mode value into the device through the address lines. Last, it hands a refresh-rate count to the refresh timer with a one-cycle load strobe and raises a sticky completion flag.

The order of the steps never changes. Each gap between two commands comes from a cycle-count input, so a single instance serves parts with different timing. The inputs are assumed to stay constant while the sequence runs. A registered output stage can be selected by parameter; with it, every command pin, the load strobe and the completion flag appear one cycle later. Clock enable is not delayed.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, clock enable is low, the command pins carry NOP, and the load strobe and the completion flag are low.
- R2: Clock enable goes high in cycle 1 after reset release and stays high. Counting the reset-release cycle as cycle 0, no command other than NOP appears before cycle S, where S is the startup count.
- R3: A single precharge-all is issued in cycle S. During it, address bit 10 is 1 and every other address and bank bit is 0.
- R4: N auto-refresh commands follow. The first is in cycle S+P, where P is the precharge gap, and each later one comes C cycles after the one before it, where C is the refresh gap.
- R5: A load-mode command is issued in cycle S+P+N·C. It places the mode value on the address lines and drives the bank address to 0.
- R6: The load strobe pulses for exactly one cycle, in cycle S+P+N·C+M, where M is the mode gap. In that cycle the rate output carries the refresh-count input; in every other cycle the rate output is 0.
- R7: The completion flag rises in the cycle after the load strobe and then stays high with NOP on the pins until the next reset.
- R8: A gap or startup count of 0 behaves as 1, and a refresh burst length of 0 behaves as 1.
- R9: Command pins are encoded as {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge = 0010, refresh = 0001, load mode = 0000. Every cycle that carries no command drives NOP with address and bank at 0.
- R10: Asserting reset in the middle of the sequence returns the outputs to the R1 state at the next clock edge. After release, the sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| startup_cycles | input | SW | Cycles from reset release to the precharge |
| trp_cycles | input | TW | Gap after the precharge |
| trc_cycles | input | TW | Gap after each auto-refresh |
| tmrd_cycles | input | TW | Gap after load mode |
| refresh_burst | input | BW | Number of auto-refresh commands |
| mode_value | input | ADDR_W | Mode value placed on the address lines |
| refresh_count | input | RW | Count handed to the refresh timer |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address lines |
| sd_ba | output | BA_W | SDRAM bank address |
| rate_load | output | 1 | One-cycle strobe that loads the refresh timer |
| rate_value | output | RW | Refresh count, valid while the strobe is high |
| init_done | output | 1 | Sequence complete; normal accesses allowed |

## Verification
The hardest case to reach from the ports is a gap of one cycle or less. The next command must then follow with no wait state, and the counter must not wrap. Directed runs therefore set every gap and the burst length to 0 and to 1. Random runs place the refreshes at many different spacings. A reset in the middle of the refresh burst checks that the burst count clears and that a full sequence follows. Every cycle of every run is compared with an expected pin vector computed from S, P, C, N and M.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR  = 4'b0000,
      CMD_AREF = 4'b0001,
      CMD_PALL = 4'b0010,
      CMD_NOP  = 4'b0111
   } sd_cmd_e;

   typedef enum logic [3:0] {
      ST_CKE,
      ST_W_START,
      ST_PALL,
      ST_W_RP,
      ST_AREF,
      ST_W_RC,
      ST_LMR,
      ST_W_MRD,
      ST_LOAD,
      ST_DONE
   } seq_state_e;

   localparam int unsigned ALL_BANKS_BIT = 10;

endpackage

// File: rtl/sdram_init_gap_timer.sv
module sdram_init_gap_timer #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] gap,
   output logic          expire
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] gap_eff;

   always_comb begin
      gap_eff = (gap == '0) ? CW'(1) : gap;
      expire  = load ? (gap_eff == CW'(1)) : (cnt_q == CW'(1));
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= gap_eff - CW'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   // R8: once a gap expires without a reload, the count has run out
   a_r8_expire_drains: assert property (@(posedge clk) disable iff (rst)
      (expire && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/sdram_init_burst_ctr.sv
module sdram_init_burst_ctr #(
   parameter int unsigned BW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic          step,
   input  logic [BW-1:0] target,
   output logic          last_step,
   output logic          all_done
);

   logic [BW-1:0] cnt_q;
   logic [BW-1:0] tgt_eff;

   always_comb begin
      tgt_eff   = (target == '0) ? BW'(1) : target;
      last_step = (cnt_q == tgt_eff - BW'(1));
      all_done  = (cnt_q == tgt_eff);
   end

   always_ff @(posedge clk) begin
      if (rst || clear)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + BW'(1);
   end

   // R4: never more refreshes than the burst length asks for
   a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
      step |-> (cnt_q < tgt_eff));

endmodule

// File: rtl/sdram_init_pin_drive.sv
module sdram_init_pin_drive
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BA_W    = 2,
   parameter int unsigned RW      = 13,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  sd_cmd_e           cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BA_W-1:0]   ba,
   input  logic              done,
   input  logic              load,
   input  logic [RW-1:0]     rate,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BA_W-1:0]   sd_ba,
   output logic              rate_load,
   output logic [RW-1:0]     rate_value,
   output logic              init_done
);

   localparam int unsigned PW = 4 + ADDR_W + BA_W + 1 + RW + 1;
   localparam logic [PW-1:0] PK_RST = {CMD_NOP, {(PW-4){1'b0}}};

   logic [PW-1:0] pk_d;
   logic [PW-1:0] pk_o;
   logic          cke_q;

   assign pk_d = {cmd, addr, ba, load, (load ? rate : {RW{1'b0}}), done};

   always_ff @(posedge clk) begin
      if (rst)
         cke_q <= 1'b0;
      else
         cke_q <= 1'b1;
   end

   generate
      if (OUT_REG) begin : g_flop
         logic [PW-1:0] pk_q;
         always_ff @(posedge clk) begin
            if (rst)
               pk_q <= PK_RST;
            else
               pk_q <= pk_d;
         end
         assign pk_o = pk_q;
      end else begin : g_comb
         assign pk_o = pk_d;
      end
   endgenerate

   assign sd_cke = cke_q;
   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba,
           rate_load, rate_value, init_done} = pk_o;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BA_W    = 2,
   parameter int unsigned SW      = 16,
   parameter int unsigned TW      = 8,
   parameter int unsigned BW      = 4,
   parameter int unsigned RW      = 13,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SW-1:0]     startup_cycles,
   input  logic [TW-1:0]     trp_cycles,
   input  logic [TW-1:0]     trc_cycles,
   input  logic [TW-1:0]     tmrd_cycles,
   input  logic [BW-1:0]     refresh_burst,
   input  logic [ADDR_W-1:0] mode_value,
   input  logic [RW-1:0]     refresh_count,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BA_W-1:0]   sd_ba,
   output logic              rate_load,
   output logic [RW-1:0]     rate_value,
   output logic              init_done
);

   generate
      if (ADDR_W <= ALL_BANKS_BIT) begin : g_bad_addr
         $error("ADDR_W must exceed the all-banks address bit");
      end
      if (SW < TW) begin : g_bad_sw
         $error("SW must be at least TW");
      end
      if (BA_W < 1 || BW < 1 || RW < 1 || TW < 1) begin : g_bad_w
         $error("widths must be at least 1");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic [SW-1:0]     gap_sel;
   logic              gap_load;
   logic              gap_expire;
   logic              ref_last;
   logic              ref_all;
   sd_cmd_e           cmd;
   logic [ADDR_W-1:0] cmd_addr;

   always_comb begin
      gap_load = 1'b1;
      case (state_q)
         ST_CKE:  gap_sel = startup_cycles;
         ST_PALL: gap_sel = SW'(trp_cycles);
         ST_AREF: gap_sel = SW'(trc_cycles);
         ST_LMR:  gap_sel = SW'(tmrd_cycles);
         default: begin
            gap_sel  = '0;
            gap_load = 1'b0;
         end
      endcase
   end

   sdram_init_gap_timer #(.CW(SW)) i_gap (
      .clk    (clk),
      .rst    (rst),
      .load   (gap_load),
      .gap    (gap_sel),
      .expire (gap_expire)
   );

   sdram_init_burst_ctr #(.BW(BW)) i_burst (
      .clk       (clk),
      .rst       (rst),
      .clear     (state_q == ST_PALL),
      .step      (state_q == ST_AREF),
      .target    (refresh_burst),
      .last_step (ref_last),
      .all_done  (ref_all)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_CKE:     state_d = gap_expire ? ST_PALL : ST_W_START;
         ST_W_START: if (gap_expire) state_d = ST_PALL;
         ST_PALL:    state_d = gap_expire ? ST_AREF : ST_W_RP;
         ST_W_RP:    if (gap_expire) state_d = ST_AREF;
         ST_AREF: begin
            if (!gap_expire)
               state_d = ST_W_RC;
            else
               state_d = ref_last ? ST_LMR : ST_AREF;
         end
         ST_W_RC:    if (gap_expire) state_d = ref_all ? ST_LMR : ST_AREF;
         ST_LMR:     state_d = gap_expire ? ST_LOAD : ST_W_MRD;
         ST_W_MRD:   if (gap_expire) state_d = ST_LOAD;
         ST_LOAD:    state_d = ST_DONE;
         default:    state_d = ST_DONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_CKE;
      else
         state_q <= state_d;
   end

   always_comb begin
      cmd      = CMD_NOP;
      cmd_addr = '0;
      case (state_q)
         ST_PALL: begin
            cmd                     = CMD_PALL;
            cmd_addr[ALL_BANKS_BIT] = 1'b1;
         end
         ST_AREF: cmd = CMD_AREF;
         ST_LMR: begin
            cmd      = CMD_LMR;
            cmd_addr = mode_value;
         end
         default: ;
      endcase
   end

   sdram_init_pin_drive #(
      .ADDR_W  (ADDR_W),
      .BA_W    (BA_W),
      .RW      (RW),
      .OUT_REG (OUT_REG)
   ) i_drive (
      .clk        (clk),
      .rst        (rst),
      .cmd        (cmd),
      .addr       (cmd_addr),
      .ba         ({BA_W{1'b0}}),
      .done       (state_q == ST_DONE),
      .load       (state_q == ST_LOAD),
      .rate       (refresh_count),
      .sd_cke     (sd_cke),
      .sd_cs_n    (sd_cs_n),
      .sd_ras_n   (sd_ras_n),
      .sd_cas_n   (sd_cas_n),
      .sd_we_n    (sd_we_n),
      .sd_addr    (sd_addr),
      .sd_ba      (sd_ba),
      .rate_load  (rate_load),
      .rate_value (rate_value),
      .init_done  (init_done)
   );

   // R2: clock enable never drops once raised
   a_r2_cke_stays: assert property (@(posedge clk) disable iff (rst)
      sd_cke |=> sd_cke);

   // R3: precharge only with clock enable already high
   a_r3_pall_after_cke: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PALL) |-> sd_cke);

   // R5: mode load only after the whole refresh burst
   a_r5_refresh_before_mode: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LMR) |-> ref_all);

   // R7: completion is sticky
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DONE) |=> (state_q == ST_DONE));

   // R6: the load step lasts one cycle and hands over to completion
   a_r6_load_once: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LOAD) |=> (state_q == ST_DONE));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

   localparam int ADDR_W = 16;
   localparam int BA_W   = 2;
   localparam int SW     = 16;
   localparam int TW     = 8;
   localparam int BW     = 4;
   localparam int RW     = 13;
   localparam int VW     = 5 + ADDR_W + BA_W + 1 + RW + 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [SW-1:0]     startup_cycles = '0;
   logic [TW-1:0]     trp_cycles = '0;
   logic [TW-1:0]     trc_cycles = '0;
   logic [TW-1:0]     tmrd_cycles = '0;
   logic [BW-1:0]     refresh_burst = '0;
   logic [ADDR_W-1:0] mode_value = '0;
   logic [RW-1:0]     refresh_count = '0;
   logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [ADDR_W-1:0] sd_addr;
   logic [BA_W-1:0]   sd_ba;
   logic              rate_load;
   logic [RW-1:0]     rate_value;
   logic              init_done;

   int checks = 0;
   int errors = 0;
   int s_e, p_e, c_e, n_e, m_e;

   always #2 clk = ~clk;

   sdram_init_seq i_sdram_init_seq (
      .clk            (clk),
      .rst            (rst),
      .startup_cycles (startup_cycles),
      .trp_cycles     (trp_cycles),
      .trc_cycles     (trc_cycles),
      .tmrd_cycles    (tmrd_cycles),
      .refresh_burst  (refresh_burst),
      .mode_value     (mode_value),
      .refresh_count  (refresh_count),
      .sd_cke         (sd_cke),
      .sd_cs_n        (sd_cs_n),
      .sd_ras_n       (sd_ras_n),
      .sd_cas_n       (sd_cas_n),
      .sd_we_n        (sd_we_n),
      .sd_addr        (sd_addr),
      .sd_ba          (sd_ba),
      .rate_load      (rate_load),
      .rate_value     (rate_value),
      .init_done      (init_done)
   );

   function automatic logic [VW-1:0] observed();
      return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba,
              rate_load, rate_value, init_done};
   endfunction

   // expected pin vector in cycle k after reset release (R1..R9)
   function automatic logic [VW-1:0] expect_at(int k);
      logic              cke = (k >= 1);
      logic [3:0]        cmd = 4'b0111;
      logic [ADDR_W-1:0] ad  = '0;
      logic              ld  = 1'b0;
      logic [RW-1:0]     val = '0;
      logic              dn  = 1'b0;
      int first = s_e + p_e;
      int lmr   = first + n_e * c_e;
      int ldc   = lmr + m_e;
      if (k == s_e) begin
         cmd = 4'b0010;
         ad[10] = 1'b1;
      end else if (k >= first && k < lmr && ((k - first) % c_e) == 0) begin
         cmd = 4'b0001;
      end else if (k == lmr) begin
         cmd = 4'b0000;
         ad  = mode_value;
      end else if (k == ldc) begin
         ld  = 1'b1;
         val = refresh_count;
      end
      if (k > ldc) dn = 1'b1;
      return {cke, cmd, ad, {BA_W{1'b0}}, ld, val, dn};
   endfunction

   function automatic string tag_at(int k);
      int first = s_e + p_e;
      int lmr   = first + n_e * c_e;
      if (k == 0) return "R1";
      if (k < s_e) return "R2";
      if (k == s_e) return "R3";
      if (k >= first && k < lmr && ((k - first) % c_e) == 0) return "R4";
      if (k == lmr) return "R5";
      if (k == lmr + m_e) return "R6";
      if (k > lmr + m_e) return "R7";
      return "R9";
   endfunction

   task automatic check(string tag, int k, logic [VW-1:0] got, logic [VW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: got %h expected %h", tag, k, got, exp);
      end
   endtask

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic run_trial(string tag, int s_in, int p_in, int c_in, int n_in,
                            int m_in, logic [ADDR_W-1:0] mv, logic [RW-1:0] rc,
                            int abort_at);
      int total;
      @(negedge clk);
      rst            = 1'b1;
      startup_cycles = SW'(s_in);
      trp_cycles     = TW'(p_in);
      trc_cycles     = TW'(c_in);
      tmrd_cycles    = TW'(m_in);
      refresh_burst  = BW'(n_in);
      mode_value     = mv;
      refresh_count  = rc;
      s_e = eff(s_in); p_e = eff(p_in); c_e = eff(c_in);
      n_e = eff(n_in); m_e = eff(m_in);
      @(negedge clk);
      #1 check({tag, "/R1 in reset"}, -1, observed(), expect_at(0));
      rst = 1'b0;
      total = s_e + p_e + n_e * c_e + m_e + 3;
      for (int k = 0; k <= total; k++) begin
         if (k > 0) @(negedge clk);
         #1 check({tag, "/", tag_at(k)}, k, observed(), expect_at(k));
         if (k == abort_at) begin
            rst = 1'b1;
            @(negedge clk);
            #1 check({tag, "/R10 mid-sequence reset"}, k + 1, observed(), expect_at(0));
            break;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog: got no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (2) @(negedge clk);
      // directed corners
      run_trial("dflt", 10, 2, 6, 8, 2, 16'h0230, 13'd1500, -1);
      run_trial("ones", 1, 1, 1, 1, 1, 16'hFFFF, 13'h1FFF, -1);
      run_trial("R8",   0, 0, 0, 0, 0, 16'h0031, 13'd41, -1);
      run_trial("R8b",  3, 1, 1, 15, 1, 16'hA5A5, 13'd777, -1);
      run_trial("R10",  8, 3, 5, 8, 2, 16'h0022, 13'd900, 8 + 3 + 5 + 1);
      run_trial("R10b", 8, 3, 5, 8, 2, 16'h0022, 13'd900, -1);
      // random
      for (int t = 0; t < 20; t++) begin
         run_trial("rand", int'($urandom_range(1, 80)), int'($urandom_range(1, 8)),
                   int'($urandom_range(1, 12)), int'($urandom_range(1, 15)),
                   int'($urandom_range(1, 6)), ADDR_W'($urandom),
                   RW'($urandom), -1);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule